// File: doc/BRIEF.md
# Timer Event Flag Register

This block keeps the sticky event flags of a 16-bit capture/compare timer and routes the interrupt requests they raise. The counter, the capture latches and the compare logic sit outside it. They deliver single-cycle pulses for two capture events, two compare matches and a counter wrap from FFFFh to 0000h. Each pulse sets its flag. The flag then stays set until a two-step access on a small register bus removes it.

The clearing protocol works per flag. A bus read of the status byte arms every flag that the read sees as set. A later read or write of the low byte of that flag's own data register then clears the flag and uses up its arm bit. The data registers live outside the block, and only their addresses are observed here. The low byte of the alternate counter copy is decoded but never clears the wrap flag.

A 4-bit routing byte chooses, for each request, either the timer interrupt output or the external interrupt output. The requests are capture, compare, wrap and a global request formed from any flag. Read data is a combinational view of the addressed byte. Holding an address without a read strobe therefore has no side effect.

Top module: `tmr_evflag_regs`

## Requirements
- R1: After reset the status byte reads 00h, the routing byte reads 00h and all eight interrupt outputs are low.
- R2: Status byte bit positions are: bit 7 capture-1, bit 6 compare-1, bit 5 wrap, bit 4 capture-2, bit 3 compare-2, bits 2..0 always 0. An event pulse sets its flag, visible from the cycle after the pulse. bus_rdata shows the byte at bus_addr combinationally, with or without a strobe, and reads 00h at data-register addresses.
- R3: A bus write to the status address (0h) changes no flag.
- R4: A read or write of a flag's low data byte with no earlier status read that saw the flag set leaves the flag set.
- R5: After a status read (rd at 0h) that sees a flag set, a read or write of that flag's low byte clears only that flag. The low-byte addresses are: 2h capture-1, 3h capture-2, 4h compare-1, 5h compare-2, 6h counter (wrap).
- R6: An access to another flag's low byte neither clears an armed flag nor removes its arm.
- R7: A read or write of the alternate counter low byte (7h) never clears the wrap flag.
- R8: An event arriving in the same cycle as the clearing access keeps the flag set. That access still uses up the arm, so a second access does not clear the flag.
- R9: A status read that sees a flag at 0 does not arm it. If the flag later sets, a low-byte access without a fresh status read leaves it set.
- R10: A write to the routing address (1h) stores data bits 3..0. Bits 7..4 of the routing byte read 0.
- R11: Routing bit 1 steers the capture request (capture-1 OR capture-2), bit 2 the compare request (compare-1 OR compare-2), bit 3 the wrap request and bit 0 the global request (any flag). A 1 drives the timer output and a 0 drives the external output. Exactly one of the pair follows the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| ev_cap1 | input | 1 | Capture-1 event pulse |
| ev_cap2 | input | 1 | Capture-2 event pulse |
| ev_cmp1 | input | 1 | Compare-1 match pulse |
| ev_cmp2 | input | 1 | Compare-2 match pulse |
| ev_wrap | input | 1 | Counter wrap pulse |
| irq_cap_tmr | output | 1 | Capture request on timer line |
| irq_cap_ext | output | 1 | Capture request on external line |
| irq_cmp_tmr | output | 1 | Compare request on timer line |
| irq_cmp_ext | output | 1 | Compare request on external line |
| irq_wrap_tmr | output | 1 | Wrap request on timer line |
| irq_wrap_ext | output | 1 | Wrap request on external line |
| irq_glob_tmr | output | 1 | Global request on timer line |
| irq_glob_ext | output | 1 | Global request on external line |

## Verification
The bench first accesses a low byte with no status read. A design that cleared on any low-byte access would drop the flag there. It then accesses a neighbouring flag's low byte and the alternate counter byte while flags are armed, which catches decode mix-ups and an alternate byte that wrongly clears the wrap flag. A new event in the same cycle as the clearing access must leave the flag set, and a second access must not clear it; a clear-wins priority or an arm that survives the access would show there. A status read taken while a flag is still 0 must not arm it. The routing byte is also driven through each steering pattern with mixed flags, which exposes swapped routing bits or a wrong OR of the paired flags.

// File: rtl/tef_pkg.sv
package tef_pkg;
    localparam int NUM_FLAGS = 5;
    localparam int DATA_W    = 8;
    localparam int PAD_W     = DATA_W - NUM_FLAGS;
    localparam int ROUTE_W   = 4;
    // Flag index inside the packed flag vector; index + PAD_W is the status bit
    localparam int F_CMP2 = 0;
    localparam int F_CAP2 = 1;
    localparam int F_WRAP = 2;
    localparam int F_CMP1 = 3;
    localparam int F_CAP1 = 4;
    // Routing bit positions
    localparam int RT_GLOB = 0;
    localparam int RT_CAP  = 1;
    localparam int RT_CMP  = 2;
    localparam int RT_WRAP = 3;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;

    typedef struct packed {
        logic flag;
        logic arm;
    } cell_state_t;
endpackage

// File: rtl/tef_flag_cell.sv
module tef_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic stat_rd_i,
    input  logic clr_acc_i,
    output logic flag_o
);
    import tef_pkg::*;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stat_rd_i && st_q.flag) begin
            st_d.arm = 1'b1;
        end
        if (clr_acc_i && st_q.arm) begin
            st_d.arm  = 1'b0;
            st_d.flag = 1'b0;
        end
        if (ev_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R5
    clear_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(st_q.arm && clr_acc_i));

    // R8
    event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_i |=> st_q.flag);

    // R9
    arm_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.arm) |-> $past(st_q.flag && stat_rd_i));
endmodule

// File: rtl/tef_route_reg.sv
module tef_route_reg #(
    parameter int DATA_W  = 8,
    parameter int ROUTE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] route_o
);
    localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << ROUTE_W) - 1);

    logic [DATA_W-1:0] route_d, route_q;

    always_comb begin
        route_d = route_q;
        if (wr_i) begin
            route_d = wdata_i & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    assign route_o = route_q;

    // R10
    route_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (route_q[DATA_W-1:ROUTE_W] == '0));
endmodule

// File: rtl/tef_irq_steer.sv
module tef_irq_steer (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic sel_tmr_i,
    output logic tmr_o,
    output logic ext_o
);
    assign tmr_o = req_i & sel_tmr_i;
    assign ext_o = req_i & ~sel_tmr_i;

    // R11
    steer_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr_o && ext_o) && ((tmr_o || ext_o) == req_i));
endmodule

// File: rtl/tmr_evflag_regs.sv
module tmr_evflag_regs #(
    parameter int                  ADDR_W     = 4,
    parameter logic [ADDR_W-1:0]   A_STATUS   = 'd0,
    parameter logic [ADDR_W-1:0]   A_ROUTE    = 'd1,
    parameter logic [ADDR_W-1:0]   A_CAP1_LO  = 'd2,
    parameter logic [ADDR_W-1:0]   A_CAP2_LO  = 'd3,
    parameter logic [ADDR_W-1:0]   A_CMP1_LO  = 'd4,
    parameter logic [ADDR_W-1:0]   A_CMP2_LO  = 'd5,
    parameter logic [ADDR_W-1:0]   A_CNT_LO   = 'd6,
    parameter logic [ADDR_W-1:0]   A_ALT_LO   = 'd7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              ev_cap1,
    input  logic              ev_cap2,
    input  logic              ev_cmp1,
    input  logic              ev_cmp2,
    input  logic              ev_wrap,
    output logic              irq_cap_tmr,
    output logic              irq_cap_ext,
    output logic              irq_cmp_tmr,
    output logic              irq_cmp_ext,
    output logic              irq_wrap_tmr,
    output logic              irq_wrap_ext,
    output logic              irq_glob_tmr,
    output logic              irq_glob_ext
);
    import tef_pkg::*;

    localparam int NUM_REQ = 4;
    localparam logic [ADDR_W-1:0] CLR_ADDR [NUM_FLAGS] =
        '{A_CMP2_LO, A_CAP2_LO, A_CNT_LO, A_CMP1_LO, A_CAP1_LO};

    flag_vec_t         ev_vec, flags, clr_acc;
    logic              stat_rd, route_wr, any_acc;
    logic [DATA_W-1:0] route;
    logic [NUM_REQ-1:0] req, sel, tmr_v, ext_v;

    assign ev_vec[F_CAP1] = ev_cap1;
    assign ev_vec[F_CMP1] = ev_cmp1;
    assign ev_vec[F_WRAP] = ev_wrap;
    assign ev_vec[F_CAP2] = ev_cap2;
    assign ev_vec[F_CMP2] = ev_cmp2;

    assign any_acc  = bus_rd | bus_wr;
    assign stat_rd  = bus_rd && (bus_addr == A_STATUS);
    assign route_wr = bus_wr && (bus_addr == A_ROUTE);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            assign clr_acc[gi] = any_acc && (bus_addr == CLR_ADDR[gi]);
            tef_flag_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .ev_i      (ev_vec[gi]),
                .stat_rd_i (stat_rd),
                .clr_acc_i (clr_acc[gi]),
                .flag_o    (flags[gi])
            );
        end
    endgenerate

    tef_route_reg #(
        .DATA_W  (DATA_W),
        .ROUTE_W (ROUTE_W)
    ) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (route_wr),
        .wdata_i (bus_wdata),
        .route_o (route)
    );

    assign req[RT_GLOB] = |flags;
    assign req[RT_CAP]  = flags[F_CAP1] | flags[F_CAP2];
    assign req[RT_CMP]  = flags[F_CMP1] | flags[F_CMP2];
    assign req[RT_WRAP] = flags[F_WRAP];
    assign sel          = route[NUM_REQ-1:0];

    generate
        for (gi = 0; gi < NUM_REQ; gi++) begin : g_steer
            tef_irq_steer u_steer (
                .clk       (clk),
                .rst_n     (rst_n),
                .req_i     (req[gi]),
                .sel_tmr_i (sel[gi]),
                .tmr_o     (tmr_v[gi]),
                .ext_o     (ext_v[gi])
            );
        end
    endgenerate

    assign irq_glob_tmr = tmr_v[RT_GLOB];
    assign irq_glob_ext = ext_v[RT_GLOB];
    assign irq_cap_tmr  = tmr_v[RT_CAP];
    assign irq_cap_ext  = ext_v[RT_CAP];
    assign irq_cmp_tmr  = tmr_v[RT_CMP];
    assign irq_cmp_ext  = ext_v[RT_CMP];
    assign irq_wrap_tmr = tmr_v[RT_WRAP];
    assign irq_wrap_ext = ext_v[RT_WRAP];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_STATUS) begin
            bus_rdata = {flags, {PAD_W{1'b0}}};
        end else if (bus_addr == A_ROUTE) begin
            bus_rdata = route;
        end
    end

    // R7
    alt_keeps_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_acc && bus_addr == A_ALT_LO && flags[F_WRAP]) |=> flags[F_WRAP]);

    // R3
    status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_STATUS) |=> ($past(flags) & ~flags) == '0);
endmodule

// File: tb/tmr_evflag_regs_bench.sv
module tmr_evflag_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 5000;
    localparam int NV         = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ev_cap1 = 0, ev_cap2 = 0, ev_cmp1 = 0, ev_cmp2 = 0, ev_wrap = 0;
    logic       irq_cap_tmr, irq_cap_ext, irq_cmp_tmr, irq_cmp_ext;
    logic       irq_wrap_tmr, irq_wrap_ext, irq_glob_tmr, irq_glob_ext;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_evflag_regs u_tmr_evflag_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_cap1(ev_cap1), .ev_cap2(ev_cap2), .ev_cmp1(ev_cmp1),
        .ev_cmp2(ev_cmp2), .ev_wrap(ev_wrap),
        .irq_cap_tmr(irq_cap_tmr), .irq_cap_ext(irq_cap_ext),
        .irq_cmp_tmr(irq_cmp_tmr), .irq_cmp_ext(irq_cmp_ext),
        .irq_wrap_tmr(irq_wrap_tmr), .irq_wrap_ext(irq_wrap_ext),
        .irq_glob_tmr(irq_glob_tmr), .irq_glob_ext(irq_glob_ext)
    );

    // Vector: ev{cap1,cmp1,wrap,cap2,cmp2}, rd, wr, addr, wdata, status expected after
    localparam logic [26:0] VECS [NV] = '{
        {5'b10000, 1'b0, 1'b0, 4'h0, 8'h00, 8'h80},  // R2 capture-1 sets bit 7
        {5'b00001, 1'b0, 1'b0, 4'h0, 8'h00, 8'h88},  // R2 compare-2 sets bit 3
        {5'b00000, 1'b0, 1'b1, 4'h2, 8'hA5, 8'h88},  // R4 no arm yet
        {5'b00000, 1'b1, 1'b0, 4'h0, 8'h00, 8'h88},  // arm capture-1, compare-2
        {5'b00000, 1'b1, 1'b0, 4'h4, 8'h00, 8'h88},  // R6 other low byte
        {5'b00000, 1'b0, 1'b1, 4'h2, 8'h3C, 8'h08},  // R5 write clears capture-1
        {5'b00100, 1'b0, 1'b0, 4'h0, 8'h00, 8'h28},  // R2 wrap sets bit 5
        {5'b00000, 1'b1, 1'b0, 4'h0, 8'h00, 8'h28},  // arm wrap
        {5'b00000, 1'b1, 1'b0, 4'h7, 8'h00, 8'h28},  // R7 alternate byte read
        {5'b00000, 1'b0, 1'b1, 4'h7, 8'h11, 8'h28},  // R7 alternate byte write
        {5'b00000, 1'b0, 1'b1, 4'h0, 8'hFF, 8'h28},  // R3 status write inert
        {5'b00000, 1'b1, 1'b0, 4'h6, 8'h00, 8'h08},  // R5 counter low clears wrap
        {5'b00000, 1'b1, 1'b0, 4'h5, 8'h00, 8'h00},  // R5 compare-2 cleared by read, R6 arm kept
        {5'b00010, 1'b0, 1'b0, 4'h0, 8'h00, 8'h10},  // R2 capture-2 sets bit 4
        {5'b00000, 1'b1, 1'b0, 4'h3, 8'h00, 8'h10},  // R9 earlier reads saw 0
        {5'b00000, 1'b1, 1'b0, 4'h0, 8'h00, 8'h10},  // arm capture-2
        {5'b00010, 1'b0, 1'b1, 4'h3, 8'h55, 8'h10},  // R8 event beats clear
        {5'b00000, 1'b0, 1'b1, 4'h3, 8'h55, 8'h10},  // R8 arm was used up
        {5'b00000, 1'b1, 1'b0, 4'h0, 8'h00, 8'h10},  // re-arm
        {5'b00000, 1'b1, 1'b0, 4'h3, 8'h00, 8'h00},  // R5 capture-2 cleared
        {5'b01000, 1'b1, 1'b0, 4'h0, 8'h00, 8'h40},  // R9 read with flag 0 same cycle as event
        {5'b00000, 1'b0, 1'b1, 4'h4, 8'h99, 8'h40}   // R9 no arm, compare-1 stays
    };

    function automatic logic [7:0] exp_irq(input logic [7:0] st, input logic [7:0] rt);
        logic cap, cmp, wrp, any;
        cap = st[7] | st[4];
        cmp = st[6] | st[3];
        wrp = st[5];
        any = |st[7:3];
        return {any & rt[0], any & ~rt[0], wrp & rt[3], wrp & ~rt[3],
                cmp & rt[2], cmp & ~rt[2], cap & rt[1], cap & ~rt[1]};
    endfunction

    function automatic logic [7:0] act_irq();
        return {irq_glob_tmr, irq_glob_ext, irq_wrap_tmr, irq_wrap_ext,
                irq_cmp_tmr, irq_cmp_ext, irq_cap_tmr, irq_cap_ext};
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic [4:0] ev, input logic rd, input logic wr,
                             input logic [3:0] addr, input logic [7:0] wd);
        @(negedge clk);
        {ev_cap1, ev_cmp1, ev_wrap, ev_cap2, ev_cmp2} = ev;
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(posedge clk);
        #1;
        {ev_cap1, ev_cmp1, ev_wrap, ev_cap2, ev_cmp2} = '0;
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic peek(input logic [3:0] addr, output logic [7:0] val);
        bus_addr = addr;
        #1;
        val = bus_rdata;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] rt;
        #(CLK_PERIOD*2 + 2);
        // R1 reset state
        peek(4'h0, v); check8("R1 status", v, 8'h00);
        peek(4'h1, v); check8("R1 route", v, 8'h00);
        check8("R1 irq", act_irq(), 8'h00);
        rst_n = 1'b1;
        // R10 route write keeps low nibble
        bus_cycle(5'b0, 0, 1, 4'h1, 8'hFF);
        peek(4'h1, v); check8("R10 route FF", v, 8'h0F);
        bus_cycle(5'b0, 0, 1, 4'h1, 8'hFA);
        peek(4'h1, v); check8("R10 route FA", v, 8'h0A);
        rt = 8'h0A;
        // Vector walk
        for (int i = 0; i < NV; i++) begin
            bus_cycle(VECS[i][26:22], VECS[i][21], VECS[i][20], VECS[i][19:16], VECS[i][15:8]);
            peek(4'h0, v);
            check8($sformatf("R2/R5 vector %0d status", i), v, VECS[i][7:0]);
            check8($sformatf("R11 vector %0d irq", i), act_irq(), exp_irq(VECS[i][7:0], rt));
        end
        // R2 data-register addresses read 0
        peek(4'h4, v); check8("R2 data addr reads 0", v, 8'h00);
        // R11 steering patterns with mixed flags
        bus_cycle(5'b00101, 0, 0, 4'h0, 8'h00);
        peek(4'h0, v); check8("R2 mixed flags", v, 8'h68);
        for (int p = 0; p < 16; p += 5) begin
            bus_cycle(5'b0, 0, 1, 4'h1, 8'(p));
            rt = 8'(p);
            check8($sformatf("R11 route %0d", p), act_irq(), exp_irq(8'h68, rt));
        end
        // R1 reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0; #1;
        peek(4'h0, v); check8("R1 status after reset", v, 8'h00);
        peek(4'h1, v); check8("R1 route after reset", v, 8'h00);
        check8("R1 irq after reset", act_irq(), 8'h00);
        @(negedge clk); rst_n = 1'b1;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule